// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block is the request and arbitration core of an eight-line interrupt controller. It samples eight raw interrupt levels every clock and keeps a request register. A per-line trigger-mode bit chooses between level capture, where the request follows the pin, and edge capture, where a request is latched on a low-to-high transition and stays until it is cleared from outside. From the unmasked requests, the in-service lines and a rotation base, it works out whether a line should interrupt the processor now, and which one.

Command decoding, vector generation and the acknowledge sequence live outside. They supply the mask, the in-service vector, the rotation base, the nesting option and a per-line clear strobe. A compile-time parameter picks a master or a slave instance. That choice sets which lines may be switched to level mode, and whether the nesting option may exclude the cascade line (line 2) from the in-service comparison.

Top module: `irq_prio_resolver`

## Requirements
- R1: A line whose trigger-mode bit is 1 (level mode) has its request bit equal to the input level sampled at the previous clock edge. Its clear strobe has no effect.
- R2: A line whose trigger-mode bit is 0 (edge mode) sets its request bit at a clock edge where the input is high and was low at the edge before.
- R3: In edge mode a low input never clears the request bit. Only the line's `req_clr` bit clears it, and a new rising edge in the same cycle takes precedence over the clear.
- R4: A write strobe loads the trigger-mode register with the written byte ANDed with a fixed mask: 0xF8 on a master instance and 0xDE on a slave instance.
- R5: Candidates are the request bits whose mask bit is 0. With no candidate, `int_valid` is 0.
- R6: Priority rank k belongs to line (rot_base + k) mod 8, and rank 0 is the highest. The winning candidate is the one with the lowest rank.
- R7: An interrupt is signalled only when the winning rank is strictly lower than the rank of the best in-service line. An empty in-service vector counts as rank 8, and an equal rank gives no interrupt.
- R8: On a master instance with `nest_en` = 1, the in-service bit of line 2 is left out of the in-service rank. A slave instance ignores `nest_en`.
- R9: `int_line` equals (winning rank + rot_base) mod 8. `int_valid` and `int_line` are registered and reflect the request register and control inputs one clock earlier.
- R10: After reset the request register, the trigger-mode register and `int_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_lvl | input | 8 | Raw interrupt input levels |
| req_clr | input | 8 | Per-line clear of edge-mode request bits |
| tmode_we | input | 1 | Trigger-mode register write strobe |
| tmode_wdata | input | 8 | Trigger-mode write data (1 = level) |
| imask | input | 8 | Mask register, 1 blocks the line |
| insvc | input | 8 | In-service register |
| rot_base | input | 3 | Line holding rank 0 |
| nest_en | input | 1 | Nesting option (master only) |
| tmode | output | 8 | Current trigger-mode register |
| req | output | 8 | Current request register |
| int_valid | output | 1 | An interrupt should be raised |
| int_line | output | 3 | Line to interrupt with, meaningful when int_valid is 1 |

## Verification
The hardest situations to reach are a candidate whose rank exactly equals the best in-service rank, and the cascade line sitting in service while nesting is on. Random in-service vectors seldom line up with the rotated candidate set in either way. Directed sequences therefore hold a level-mode line high and place its own in-service bit, then a lower-ranked and a higher-ranked one. They also put line 2 in service with nesting on and off, and compare a master instance with a slave instance fed the same stimulus. Seeded random traffic then runs against a bench model of both instances across rotations, masks and trigger-mode writes.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int unsigned LINES     = 8;
  localparam int unsigned LINE_W    = $clog2(LINES);
  localparam int unsigned CASC_LINE = 2;
  localparam logic [LINES-1:0] MASTER_TMODE_MASK = 8'hF8;
  localparam logic [LINES-1:0] SLAVE_TMODE_MASK  = 8'hDE;

  function automatic logic [LINES-1:0] tmode_allow(input bit is_master);
    return is_master ? MASTER_TMODE_MASK : SLAVE_TMODE_MASK;
  endfunction
endpackage

// File: rtl/irq_line_capture.sv
module irq_line_capture #(
  parameter int unsigned NLINES = 8,
  parameter logic [NLINES-1:0] TMASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_lvl,
  input  logic [NLINES-1:0] req_clr,
  input  logic              tmode_we,
  input  logic [NLINES-1:0] tmode_wdata,
  output logic [NLINES-1:0] tmode_q,
  output logic [NLINES-1:0] req_q
);
  logic [NLINES-1:0] prev_q;
  logic [NLINES-1:0] req_n;
  logic [NLINES-1:0] tmode_n;

  assign tmode_n = tmode_wdata & TMASK;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    always_comb begin
      if (tmode_q[g]) begin
        req_n[g] = irq_lvl[g];
      end else begin
        req_n[g] = (req_q[g] & ~req_clr[g]) | (irq_lvl[g] & ~prev_q[g]);
      end
    end

    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      tmode_q[g] |=> (req_q[g] == $past(irq_lvl[g]))); // R1
    AST_EDGE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (!tmode_q[g] && irq_lvl[g] && !prev_q[g]) |=> req_q[g]); // R2
    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tmode_q[g] && !irq_lvl[g] && !req_clr[g]) |=> (req_q[g] == $past(req_q[g]))); // R3
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      req_q  <= '0;
    end else begin
      prev_q <= irq_lvl;
      req_q  <= req_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmode_q <= '0;
    end else if (tmode_we) begin
      tmode_q <= tmode_n;
    end
  end
endmodule

// File: rtl/rot_prio_find.sv
module rot_prio_find #(
  parameter int unsigned NLINES = 8,
  parameter int unsigned IDW    = $clog2(NLINES),
  localparam int unsigned PW    = IDW + 1
) (
  input  logic [NLINES-1:0] vec,
  input  logic [IDW-1:0]    base,
  output logic [PW-1:0]     rank
);
  logic [IDW-1:0] idx;

  always_comb begin
    rank = PW'(NLINES);
    idx  = '0;
    for (int k = NLINES - 1; k >= 0; k--) begin
      idx = IDW'(k) + base;
      if (vec[idx]) begin
        rank = PW'(k);
      end
    end
  end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_res_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1,
  localparam int unsigned NL  = LINES,
  localparam int unsigned IW  = LINE_W,
  localparam int unsigned RW  = IW + 1,
  localparam logic [NL-1:0] TMASK = tmode_allow(IS_MASTER)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    irq_lvl,
  input  logic [7:0]    req_clr,
  input  logic          tmode_we,
  input  logic [7:0]    tmode_wdata,
  input  logic [7:0]    imask,
  input  logic [7:0]    insvc,
  input  logic [2:0]    rot_base,
  input  logic          nest_en,
  output logic [7:0]    tmode,
  output logic [7:0]    req,
  output logic          int_valid,
  output logic [2:0]    int_line
);
  logic          rst_meta_q;
  logic          rst_sync_q;
  logic [NL-1:0] cand;
  logic [NL-1:0] isv_eff;
  logic [RW-1:0] req_rank;
  logic [RW-1:0] isv_rank;
  logic          win;
  logic [IW-1:0] line_n;
  logic          valid_q;
  logic [IW-1:0] line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  irq_line_capture #(.NLINES(NL), .TMASK(TMASK)) i_capture (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .irq_lvl    (irq_lvl),
    .req_clr    (req_clr),
    .tmode_we   (tmode_we),
    .tmode_wdata(tmode_wdata),
    .tmode_q    (tmode),
    .req_q      (req)
  );

  assign cand = req & ~imask;

  if (IS_MASTER) begin : g_master_isv
    always_comb begin
      isv_eff = insvc;
      if (nest_en) begin
        isv_eff[CASC_LINE] = 1'b0;
      end
    end
  end else begin : g_slave_isv
    assign isv_eff = insvc;
  end

  rot_prio_find #(.NLINES(NL), .IDW(IW)) i_req_rank (
    .vec (cand),
    .base(rot_base),
    .rank(req_rank)
  );

  rot_prio_find #(.NLINES(NL), .IDW(IW)) i_isv_rank (
    .vec (isv_eff),
    .base(rot_base),
    .rank(isv_rank)
  );

  assign win    = (req_rank < isv_rank);
  assign line_n = req_rank[IW-1:0] + rot_base;

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= win;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      line_q <= '0;
    end else if (win) begin
      line_q <= line_n;
    end
  end

  assign int_valid = valid_q;
  assign int_line  = line_q;

  AST_NO_CAND_NO_INT: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (cand == '0) |=> !int_valid); // R5
  AST_WINNER_IS_CAND: assert property (@(posedge clk) disable iff (!rst_sync_q)
    int_valid |-> (|($past(cand) & (NL'(1) << int_line)))); // R9
  AST_TOP_ISV_BLOCKS: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (insvc[rot_base] && !(IS_MASTER && nest_en && (rot_base == IW'(CASC_LINE))))
      |=> !int_valid); // R7
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_sync_q |-> (!int_valid && (req == '0) && (tmode == '0))); // R10
endmodule

// File: tb/test_irq_prio_resolver.sv
module test_irq_prio_resolver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_lvl = '0;
  logic [7:0] req_clr = '0;
  logic       tmode_we = 1'b0;
  logic [7:0] tmode_wdata = '0;
  logic [7:0] imask = '0;
  logic [7:0] insvc = '0;
  logic [2:0] rot_base = '0;
  logic       nest_en = 1'b0;

  logic [7:0] m_tmode, m_req, s_tmode, s_req;
  logic       m_valid, s_valid;
  logic [2:0] m_line, s_line;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_prio_resolver #(.IS_MASTER(1'b1)) i_irq_prio_resolver (
    .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .req_clr(req_clr),
    .tmode_we(tmode_we), .tmode_wdata(tmode_wdata), .imask(imask),
    .insvc(insvc), .rot_base(rot_base), .nest_en(nest_en),
    .tmode(m_tmode), .req(m_req), .int_valid(m_valid), .int_line(m_line));

  irq_prio_resolver #(.IS_MASTER(1'b0)) i_irq_prio_resolver_slv (
    .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .req_clr(req_clr),
    .tmode_we(tmode_we), .tmode_wdata(tmode_wdata), .imask(imask),
    .insvc(insvc), .rot_base(rot_base), .nest_en(nest_en),
    .tmode(s_tmode), .req(s_req), .int_valid(s_valid), .int_line(s_line));

  // Bench model derived from the requirements
  function automatic logic [3:0] resolve(input logic [7:0] rq, input logic [7:0] mk,
                                         input logic [7:0] isv, input logic [2:0] base,
                                         input logic nest, input bit master);
    logic [7:0] c;
    logic [7:0] iv;
    int p;
    int cur;
    logic [2:0] ln;
    c = rq & ~mk;
    iv = isv;
    if (master && nest) iv[2] = 1'b0;
    p = 8;
    cur = 8;
    for (int k = 7; k >= 0; k--) begin
      ln = 3'(k) + base;
      if (c[ln]) p = k;
      if (iv[ln]) cur = k;
    end
    if (p < cur) return {1'b1, 3'(p) + base};
    return 4'b0;
  endfunction

  function automatic logic [7:0] next_req(input logic [7:0] rq, input logic [7:0] pv,
                                          input logic [7:0] tm, input logic [7:0] lv,
                                          input logic [7:0] cl);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = tm[i] ? lv[i] : ((rq[i] & ~cl[i]) | (lv[i] & ~pv[i]));
    return r;
  endfunction

  logic [7:0] e_mtm, e_mrq, e_stm, e_srq, e_prev;
  logic [3:0] e_m, e_s;

  always @(posedge clk) begin
    if (!rst_n) begin
      e_mtm <= '0; e_mrq <= '0; e_stm <= '0; e_srq <= '0; e_prev <= '0;
      e_m <= '0; e_s <= '0;
    end else begin
      e_m    <= resolve(e_mrq, imask, insvc, rot_base, nest_en, 1'b1);
      e_s    <= resolve(e_srq, imask, insvc, rot_base, nest_en, 1'b0);
      e_mrq  <= next_req(e_mrq, e_prev, e_mtm, irq_lvl, req_clr);
      e_srq  <= next_req(e_srq, e_prev, e_stm, irq_lvl, req_clr);
      e_prev <= irq_lvl;
      if (tmode_we) begin
        e_mtm <= tmode_wdata & 8'hF8;
        e_stm <= tmode_wdata & 8'hDE;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic compare_model();
    chk("R1 R2 R3 master req", m_req, e_mrq);
    chk("R1 R2 R3 slave req", s_req, e_srq);
    chk("R4 master tmode", m_tmode, e_mtm);
    chk("R4 slave tmode", s_tmode, e_stm);
    chk("R5 R7 R8 master valid", m_valid, e_m[3]);
    chk("R5 R7 R8 slave valid", s_valid, e_s[3]);
    if (e_m[3]) chk("R6 R9 master line", m_line, e_m[2:0]);
    if (e_s[3]) chk("R6 R9 slave line", s_line, e_s[2:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(4);
    // R10 reset state
    chk("R10 req", m_req, 8'h00);
    chk("R10 tmode", m_tmode, 8'h00);
    chk("R10 valid", m_valid, 1'b0);

    // R4 masked trigger-mode write
    tmode_we = 1'b1; tmode_wdata = 8'hFF;
    tick();
    tmode_we = 1'b0;
    chk("R4 master mask", m_tmode, 8'hF8);
    chk("R4 slave mask", s_tmode, 8'hDE);

    // R2 R3 edge line 0
    irq_lvl = 8'h01;
    tick();
    chk("R2 edge set", m_req[0], 1'b1);
    irq_lvl = 8'h00;
    tick();
    chk("R3 low keeps edge request", m_req[0], 1'b1);
    chk("R9 line 0 reported", {m_valid, m_line}, 4'b1000);
    req_clr = 8'h01;
    tick();
    req_clr = 8'h00;
    chk("R3 clear strobe", m_req[0], 1'b0);

    // R1 level line 3, clear ignored
    irq_lvl = 8'h08; req_clr = 8'h08;
    tick();
    req_clr = 8'h00;
    chk("R1 level high", m_req[3], 1'b1);
    irq_lvl = 8'h00;
    tick();
    chk("R1 level low", m_req[3], 1'b0);

    // R7 strict comparison with line 4 held
    irq_lvl = 8'h10; insvc = 8'h10;
    tick(2);
    chk("R7 equal rank blocks", m_valid, 1'b0);
    insvc = 8'h20;
    tick(2);
    chk("R7 lower in-service passes", {m_valid, m_line}, 4'b1100);
    insvc = 8'h08;
    tick(2);
    chk("R7 higher in-service blocks", m_valid, 1'b0);
    imask = 8'h10; insvc = 8'h00;
    tick(2);
    chk("R5 masked line gives none", m_valid, 1'b0);
    imask = 8'h00;

    // R8 cascade line in service
    insvc = 8'h04; nest_en = 1'b1;
    tick(2);
    chk("R8 master nests past line 2", {m_valid, m_line}, 4'b1100);
    chk("R8 slave ignores nesting", s_valid, 1'b0);
    nest_en = 1'b0;
    tick(2);
    chk("R8 master without nesting", m_valid, 1'b0);
    insvc = 8'h00;

    // R6 rotation
    irq_lvl = 8'h50; rot_base = 3'd5;
    tick(2);
    chk("R6 base 5 picks line 6", {m_valid, m_line}, 4'b1110);
    rot_base = 3'd7;
    tick(2);
    chk("R6 base 7 picks line 4", {m_valid, m_line}, 4'b1100);

    // Random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      irq_lvl     = 8'($urandom);
      req_clr     = 8'($urandom & $urandom);
      imask       = 8'($urandom & $urandom & $urandom);
      insvc       = ($urandom % 3 == 0) ? 8'($urandom & $urandom & $urandom) : 8'h00;
      rot_base    = 3'($urandom);
      nest_en     = 1'($urandom);
      tmode_we    = ($urandom % 16 == 0);
      tmode_wdata = 8'($urandom);
      tick();
      compare_model();
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule